// File: doc/BRIEF.md
# Eight-Byte Column MDS Multiplier

This block multiplies one column of eight bytes by a fixed 8x8 circulant matrix over GF(2^8), the diffusion step of a wide permutation-based hash round. Every product is a multiplication by a small constant: 2, 3, 4, 5 or 7. Each one is formed from repeated doubling (xtime) and XOR, so the unit needs no lookup tables.

Two internal datapaths compute the same result. The direct path forms each output byte as the sum of its eight weighted input bytes. The factored path runs a shared chain of neighbour XORs with only two doubling stages. A select input chooses which path drives the output. Both paths are always compared inside the block, so a wrong factoring shows up at once. By default the result is captured in a register one cycle after a valid column is presented. A parameter can instead make the unit purely combinational.

Top module: `grs_column_mixer`

## Requirements
- R1: Input byte a_i sits at `col_in[8*i+7:8*i]` and output byte b_i at `col_out[8*i+7:8*i]`, for i = 0..7.
- R2: b_i equals the GF(2^8) sum over j = 0..7 of c_j times a_((i+j) mod 8), where c = (2,2,3,4,5,3,5,7). Row 0 therefore uses coefficients 2,2,3,4,5,3,5,7 and row 1 uses 7,2,2,3,4,5,3,5.
- R3: Doubling shifts a byte left by one bit and XORs in 0x1B when the bit shifted out was 1. For example, a column whose only nonzero byte is a0 = 0x80 gives b0 = 0x1B.
- R4: With `path_sel` = 0 the direct path drives the output, and with `path_sel` = 1 the factored path drives it. Both give the same column for every input.
- R5: In the default registered form, `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high. `col_out` then holds the result for that input.
- R6: When `in_valid` is low, `col_out` keeps its previous value whatever `col_in` and `path_sel` do.
- R7: An all-zero input column gives an all-zero output column.
- R8: The map is linear: the output for a XOR c equals the XOR of the outputs for a and for c.
- R9: The XOR of the eight output bytes equals 3 times the XOR of the eight input bytes.
- R10: During and right after reset, `out_valid` is 0 and `col_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | A column is presented on `col_in` |
| path_sel | input | 1 | 0 selects the direct path, 1 selects the factored path |
| col_in | input | 64 | Input column, byte i at bits 8i+7:8i |
| out_valid | output | 1 | Result on `col_out` is new this cycle |
| col_out | output | 64 | Output column, byte i at bits 8i+7:8i |

## Verification
The assertions assume that `in_valid` is 0 while reset is held and that `col_in` carries known values whenever `in_valid` is high. Only then do the path-agreement and column-sum properties compare defined data. The bench drives both inputs from reset onward and changes them only on the falling edge, so neither assumption is broken. When `in_valid` is low the bench deliberately changes the column contents, to test the hold behaviour, but the assertions that look at data are gated by `in_valid` and do not check those cycles.

// File: rtl/grs_mix_pkg.sv
package grs_mix_pkg;
  localparam int unsigned GF_W   = 8;
  localparam int unsigned LANES  = 8;
  localparam int unsigned IDX_W  = $clog2(LANES);
  localparam int unsigned COL_W  = GF_W * LANES;
  localparam int unsigned COEF_W = 3;

  typedef logic [GF_W-1:0] gf_t;
  typedef gf_t [LANES-1:0] col_t;

  localparam gf_t RED_LOW = 8'h1B;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic gf_t gf_x2(input gf_t v);
    return {v[GF_W-2:0], 1'b0} ^ (v[GF_W-1] ? RED_LOW : gf_t'(0));
  endfunction

  function automatic gf_t gf_x4(input gf_t v);
    return gf_x2(gf_x2(v));
  endfunction

  // constant multiply for the small coefficients used by the matrix
  function automatic gf_t gf_kmul(input gf_t v, input logic [COEF_W-1:0] k);
    gf_t r;
    case (k)
      3'd1:    r = v;
      3'd2:    r = gf_x2(v);
      3'd3:    r = gf_x2(v) ^ v;
      3'd4:    r = gf_x4(v);
      3'd5:    r = gf_x4(v) ^ v;
      3'd6:    r = gf_x4(v) ^ gf_x2(v);
      3'd7:    r = gf_x4(v) ^ gf_x2(v) ^ v;
      default: r = '0;
    endcase
    return r;
  endfunction

  // coefficient applied to the byte j places to the right of the row index
  function automatic logic [COEF_W-1:0] coef_at(input int j);
    logic [COEF_W-1:0] c;
    case (j)
      0, 1:    c = 3'd2;
      2, 5:    c = 3'd3;
      3:       c = 3'd4;
      4, 6:    c = 3'd5;
      7:       c = 3'd7;
      default: c = 3'd0;
    endcase
    return c;
  endfunction

  function automatic gf_t col_fold(input col_t c);
    gf_t r;
    r = '0;
    for (int k = 0; k < LANES; k++) r ^= c[IDX_W'(k)];
    return r;
  endfunction
endpackage

// File: rtl/grs_direct_rows.sv
module grs_direct_rows
  import grs_mix_pkg::*;
(
  input  col_t a_col,
  output col_t b_col
);
  for (genvar i = 0; i < LANES; i++) begin : g_row
    gf_t terms [LANES];
    gf_t chain [LANES+1];
    assign chain[0] = '0;
    for (genvar j = 0; j < LANES; j++) begin : g_term
      localparam int SRC = (i + j) % LANES;
      assign terms[j]    = gf_kmul(a_col[SRC], coef_at(j));
      assign chain[j+1]  = chain[j] ^ terms[j];
    end
    assign b_col[i] = chain[LANES];
  end
endmodule

// File: rtl/grs_factored_net.sv
module grs_factored_net
  import grs_mix_pkg::*;
(
  input  col_t a_col,
  output col_t b_col
);
  col_t pair_x;   // a_i ^ a_(i+1)
  col_t mix_a;    // pair_x ^ a_(i+6)
  col_t mix_b;    // mix_a ^ pair_x_(i+2)
  col_t pair_y;   // pair_x ^ pair_x_(i+3)
  col_t dbl_one;  // first doubling
  col_t acc_c;    // dbl_one ^ mix_b_(i+4)
  col_t dbl_two;  // second doubling

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int N1 = (i + 1) % LANES;
    localparam int N2 = (i + 2) % LANES;
    localparam int N3 = (i + 3) % LANES;
    localparam int N4 = (i + 4) % LANES;
    localparam int N6 = (i + 6) % LANES;
    assign pair_x[i]  = a_col[i] ^ a_col[N1];
    assign mix_a[i]   = pair_x[i] ^ a_col[N6];
    assign mix_b[i]   = mix_a[i] ^ pair_x[N2];
    assign pair_y[i]  = pair_x[i] ^ pair_x[N3];
    assign dbl_one[i] = gf_x2(pair_y[i]);
    assign acc_c[i]   = dbl_one[i] ^ mix_b[N4];
    assign dbl_two[i] = gf_x2(acc_c[i]);
    assign b_col[i]   = dbl_two[N3] ^ mix_b[N4];
  end
endmodule

// File: rtl/grs_out_stage.sv
module grs_out_stage
  import grs_mix_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
)(
  input  logic clk,
  input  logic rst_n,
  input  logic d_valid,
  input  col_t d_col,
  output logic q_valid,
  output col_t q_col
);
  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_valid <= 1'b0;
        q_col   <= '0;
      end else begin
        q_valid <= d_valid;
        if (d_valid) q_col <= d_col;
      end
    end

    // R5: result valid exactly one cycle after an accepted column
    p_valid_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |=> q_valid);
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !d_valid |=> !q_valid);
    // R6: output holds without a new column
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !d_valid |=> $stable(q_col));
  end else begin : g_comb
    assign q_valid = d_valid;
    assign q_col   = d_col;
  end
endmodule

// File: rtl/grs_column_mixer.sv
module grs_column_mixer
  import grs_mix_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             path_sel,
  input  logic [COL_W-1:0] col_in,
  output logic             out_valid,
  output logic [COL_W-1:0] col_out
);
  col_t a_col, direct_col, factored_col, sel_col, res_col;

  // events brought out for the checks
  logic paths_agree;
  gf_t  in_fold, out_fold;

  assign a_col = col_t'(col_in);

  grs_direct_rows  u_direct   (.a_col(a_col), .b_col(direct_col));
  grs_factored_net u_factored (.a_col(a_col), .b_col(factored_col));

  assign sel_col     = path_sel ? factored_col : direct_col;
  assign paths_agree = (direct_col == factored_col);
  assign in_fold     = col_fold(a_col);
  assign out_fold    = col_fold(sel_col);

  grs_out_stage #(.REGISTERED(REGISTERED)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (in_valid),
    .d_col   (sel_col),
    .q_valid (out_valid),
    .q_col   (res_col)
  );

  assign col_out = res_col;

  // R4: the two datapaths agree on every valid column
  p_paths_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> paths_agree);
  // R9: column sums relate by the factor 3
  p_column_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (out_fold == (gf_x2(in_fold) ^ in_fold)));

  if (REGISTERED) begin : g_reg_chk
    // R7: zero column produces zero result
    p_zero_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && col_in == '0) |=> (col_out == '0));
  end
endmodule

// File: tb/sim_grs_column_mixer.sv
module sim_grs_column_mixer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        path_sel = 1'b0;
  logic [63:0] col_in = '0;
  logic        out_valid;
  logic [63:0] col_out;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  grs_column_mixer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .path_sel(path_sel),
    .col_in(col_in), .out_valid(out_valid), .col_out(col_out)
  );

  // shift-and-add multiply, independent of the constant chains in the RTL
  function automatic logic [7:0] ref_mul(input logic [7:0] x, input int k);
    logic [7:0] acc, cur;
    acc = 8'h00; cur = x;
    for (int b = 0; b < 8; b++) begin
      if (k[b]) acc ^= cur;
      cur = cur[7] ? ((cur << 1) ^ 8'h1B) : (cur << 1);
    end
    return acc;
  endfunction

  function automatic logic [63:0] ref_col(input logic [63:0] a);
    int coef [8] = '{2, 2, 3, 4, 5, 3, 5, 7};
    logic [63:0] r;
    logic [7:0] s;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      s = 8'h00;
      for (int j = 0; j < 8; j++) s ^= ref_mul(a[8*((i+j)%8) +: 8], coef[j]);
      r[8*i +: 8] = s;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // present one column, return the registered result
  task automatic apply(input logic [63:0] a, input logic sel, output logic [63:0] res);
    @(negedge clk);
    col_in = a; path_sel = sel; in_valid = 1'b1;
    @(posedge clk); #1;
    res = col_out;
    checks++;
    if (out_valid !== 1'b1) begin
      failures++;
      $display("FAIL R5 out_valid got=%b exp=1", out_valid);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] r, ra, rc, rac, a, c, held;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check("R10 col_out in reset", col_out, 64'h0);
    check("R10 out_valid in reset", {63'h0, out_valid}, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 col_out after reset", col_out, 64'h0);
    check("R10 out_valid after reset", {63'h0, out_valid}, 64'h0);

    // R3: a0 = 0x80 only -> b0 = 2*0x80 = 0x1B
    apply(64'h80, 1'b0, r);
    check("R3 doubling reduction", {56'h0, r[7:0]}, 64'h1B);
    // R2 row 1 coefficient of a0 is 7: 7*0x01 = 0x07
    apply(64'h01, 1'b1, r);
    check("R2 row1 coef", {56'h0, r[15:8]}, 64'h07);
    // R7 zero column, both paths
    apply(64'h0, 1'b0, r); check("R7 zero direct", r, 64'h0);
    apply(64'h0, 1'b1, r); check("R7 zero factored", r, 64'h0);

    // R1 R2 R4: every single-byte column at every lane, both paths
    for (int p = 0; p < 8; p++) begin
      for (int v = 0; v < 256; v++) begin
        a = 64'(v) << (8 * p);
        apply(a, 1'b0, r); check("R1 R2 sweep direct", r, ref_col(a));
        apply(a, 1'b1, r); check("R4 sweep factored", r, ref_col(a));
      end
    end

    // R2 R4 R9 random columns
    for (int n = 0; n < 10000; n++) begin
      a = {$urandom, $urandom};
      apply(a, n[0], r);
      check("R2 random", r, ref_col(a));
      check("R9 column sum", {56'h0, r[7:0]^r[15:8]^r[23:16]^r[31:24]^r[39:32]^r[47:40]^r[55:48]^r[63:56]},
            {56'h0, ref_mul(a[7:0]^a[15:8]^a[23:16]^a[31:24]^a[39:32]^a[47:40]^a[55:48]^a[63:56], 3)});
    end

    // R8 linearity
    for (int n = 0; n < 300; n++) begin
      a = {$urandom, $urandom}; c = {$urandom, $urandom};
      apply(a, n[0], ra); apply(c, ~n[0], rc); apply(a ^ c, n[1], rac);
      check("R8 linearity", rac, ra ^ rc);
    end

    // R6 hold and R5 valid drop
    apply(64'h0123_4567_89AB_CDEF, 1'b0, held);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      in_valid = 1'b0; col_in = {$urandom, $urandom}; path_sel = n[0];
      @(posedge clk); #1;
      check("R6 hold", col_out, held);
      check("R5 valid low", {63'h0, out_valid}, 64'h0);
    end
    check("R6 held value", held, ref_col(64'h0123_4567_89AB_CDEF));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule